// File: doc/BRIEF.md
# Streaming Top-Three and Average Unit

This block watches a fixed-length burst of unsigned samples and reports four summary values about it: the mean and the three largest samples, ranked. A one-cycle start pulse marks the cycle in which the first sample is present on the data input. The block then takes one sample on every clock until it has seen K = 2^LOG2_K samples. While the burst streams in, it keeps a running sum in a register widened by LOG2_K bits and a ranked list of three registers. Each new sample is inserted into the list at its place, and the lower entries move down one rank.

When the last sample has been taken, the block raises `done`. The mean is the widened sum shifted right by LOG2_K bits. A 2-bit select input chooses which of the four results drives the output. The results and `done` hold until the next start pulse. A new start pulse begins a new burst at once, in any state, and discards all earlier results. The design has a datapath holding the registers, comparators, counter and output multiplexer, and a three-state controller that drives the datapath's enables and shift selects. Reset is asynchronous and active low, and it is expected to be released synchronously to `clk` by the surrounding logic.

Top module: `burst_rank_avg`

## Requirements
- R1: After reset, `done` is 0 and `dout` is 0 for every value of `mode`.
- R2: The sample present together with `start` is the first sample of the burst. The next K-1 samples are taken on the K-1 following cycles. `done` is 0 until the K-th sample has been taken and is 1 in the cycle after it, K cycles after the start edge.
- R3: When `done` is 1, the first, second and third ranked results equal the largest, second largest and third largest samples of the burst, and the three ranks are never out of order (first >= second >= third).
- R4: Equal samples occupy separate ranks. A sample equal to a ranked value does not displace it, but it takes the next lower rank if it is larger than the value held there.
- R5: The mean result equals floor(sum of the K samples / K). The sum never overflows, even when every sample is the maximum value.
- R6: The `mode` select works as follows: 2'b00 gives the mean, 2'b01 the largest sample, 2'b10 the second largest and 2'b11 the third largest.
- R7: While `done` is 1 and `start` is 0, the `din` values are ignored. `done` stays 1 and all four results stay unchanged.
- R8: A `start` pulse begins a new burst in any state, including in the middle of a burst. The results that follow depend only on the samples of the new burst.
- R9: If fewer than three samples of a burst are non-zero, the remaining ranks read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse; `din` holds the first sample of the burst in the same cycle |
| din | input | DATA_W | Unsigned sample, one per clock during a burst |
| mode | input | 2 | Result select: 00 mean, 01 largest, 10 second, 11 third |
| dout | output | DATA_W | Selected result |
| done | output | 1 | Results valid; held until the next start |

## Verification
A ranked register that takes the wrong shift select would break the order of the list or push a value out too early. This shows up at `dout` in modes 01 to 11 in the first cycle `done` is high, and the internal order check fires on the cycle after the wrong insertion. An off-by-one in the counter or the terminal count moves the rise of `done` by one cycle, and it also changes the mean by one sample's share. A failure to clear on `start` leaves values from the previous burst visible. This is caught by running bursts of small values directly after bursts of large values, and by restarting in the middle of a burst. Random bursts drawn from a narrow value range force many ties.

// File: rtl/burst_rank_pkg.sv
package burst_rank_pkg;

  localparam int unsigned RANKS = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } ctl_state_e;

  typedef enum logic [1:0] {
    SEL_AVG    = 2'b00,
    SEL_FIRST  = 2'b01,
    SEL_SECOND = 2'b10,
    SEL_THIRD  = 2'b11
  } out_sel_e;

endpackage

// File: rtl/rank_avg_datapath.sv
module rank_avg_datapath
  import burst_rank_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOG2_K = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DATA_W-1:0]              din,
  input  logic [1:0]                     mode,
  input  logic                           clr,
  input  logic                           en_acc,
  input  logic                           en_cnt,
  input  logic [RANKS-1:0]               en_rank,
  input  logic [RANKS-2:0]               sel_shift,
  output logic [RANKS-1:0]               gt,
  output logic                           tc,
  output logic [RANKS-1:0][DATA_W-1:0]   rank_q,
  output logic [DATA_W-1:0]              dout
);

  localparam int unsigned ACC_W = DATA_W + LOG2_K;
  localparam int unsigned CNT_W = (LOG2_K > 0) ? LOG2_K : 1;
  localparam int unsigned K     = 1 << LOG2_K;

  logic [ACC_W-1:0]                 acc_q, acc_eff;
  logic [CNT_W-1:0]                 cnt_q, cnt_eff;
  logic [RANKS-1:0][DATA_W-1:0]     rank_eff, rank_d;

  // A start cycle sees every register as already cleared.
  assign acc_eff = clr ? '0 : acc_q;
  assign cnt_eff = clr ? '0 : cnt_q;
  assign tc      = (cnt_eff == CNT_W'(K - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (en_acc) acc_q <= acc_eff + ACC_W'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (en_cnt) cnt_q <= cnt_eff + CNT_W'(1);
  end

  for (genvar i = 0; i < RANKS; i++) begin : g_rank
    assign rank_eff[i] = clr ? '0 : rank_q[i];
    assign gt[i]       = (din > rank_eff[i]);

    if (i == 0) begin : g_top
      assign rank_d[i] = din;
    end else begin : g_lower
      // Take the entry above (shift down) or the new sample.
      assign rank_d[i] = sel_shift[i-1] ? rank_eff[i-1] : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rank_q[i] <= '0;
      else if (en_rank[i]) rank_q[i] <= rank_d[i];
    end
  end

  always_comb begin
    unique case (out_sel_e'(mode))
      SEL_AVG:    dout = acc_q[ACC_W-1:LOG2_K];
      SEL_FIRST:  dout = rank_q[0];
      SEL_SECOND: dout = rank_q[1];
      SEL_THIRD:  dout = rank_q[2];
      default:    dout = '0;
    endcase
  end

endmodule

// File: rtl/rank_avg_ctrl.sv
module rank_avg_ctrl
  import burst_rank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RANKS-1:0] gt,
  input  logic             tc,
  output logic             clr,
  output logic             en_acc,
  output logic             en_cnt,
  output logic [RANKS-1:0] en_rank,
  output logic [RANKS-2:0] sel_shift,
  output logic             done,
  output logic             busy
);

  ctl_state_e state_q, state_d;
  logic       accept;

  assign accept = start | (state_q == ST_RUN);
  assign clr    = start;
  assign en_acc = accept;
  assign en_cnt = accept;
  assign done   = (state_q == ST_DONE);
  assign busy   = (state_q == ST_RUN);

  // The ranks are kept sorted, so gt[i] implies gt[j] for every j > i.
  always_comb begin
    for (int i = 0; i < RANKS; i++) begin
      en_rank[i] = accept & (start | gt[i]);
    end
    for (int i = 0; i < RANKS - 1; i++) begin
      sel_shift[i] = gt[i];
    end
  end

  always_comb begin
    state_d = state_q;
    if (accept) state_d = tc ? ST_DONE : ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/burst_rank_avg.sv
module burst_rank_avg
  import burst_rank_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOG2_K = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] dout,
  output logic              done
);

  logic                         clr, en_acc, en_cnt, tc, busy;
  logic [RANKS-1:0]             en_rank, gt;
  logic [RANKS-2:0]             sel_shift;
  logic [RANKS-1:0][DATA_W-1:0] rank_q;

  rank_avg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .gt        (gt),
    .tc        (tc),
    .clr       (clr),
    .en_acc    (en_acc),
    .en_cnt    (en_cnt),
    .en_rank   (en_rank),
    .sel_shift (sel_shift),
    .done      (done),
    .busy      (busy)
  );

  rank_avg_datapath #(
    .DATA_W (DATA_W),
    .LOG2_K (LOG2_K)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .mode      (mode),
    .clr       (clr),
    .en_acc    (en_acc),
    .en_cnt    (en_cnt),
    .en_rank   (en_rank),
    .sel_shift (sel_shift),
    .gt        (gt),
    .tc        (tc),
    .rank_q    (rank_q),
    .dout      (dout)
  );

endmodule

// File: rtl/burst_rank_avg_chk.sv
module burst_rank_avg_chk
  import burst_rank_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LOG2_K = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic [DATA_W-1:0]            din,
  input logic                         done,
  input logic                         busy,
  input logic [RANKS-1:0][DATA_W-1:0] rank_q
);

  localparam int unsigned K = 1 << LOG2_K;

  // Cycles since the last start edge, saturating.
  logic [31:0] since_start;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_start <= '0;
    else if (start)                since_start <= 32'd1;
    else if (since_start != '1)    since_start <= since_start + 32'd1;
  end

  assert_rank_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_q[0] >= rank_q[1]) && (rank_q[1] >= rank_q[2]));

  assert_first_covers_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start || busy) |=> (rank_q[0] >= $past(din)));

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (since_start == 32'(K)));

  assert_hold_results_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(rank_q)));

  assert_start_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((K == 1) ? done : !done));

endmodule

bind burst_rank_avg burst_rank_avg_chk #(
  .DATA_W (DATA_W),
  .LOG2_K (LOG2_K)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .din    (din),
  .done   (done),
  .busy   (busy),
  .rank_q (rank_q)
);

// File: tb/tb_burst_rank_avg.sv
module tb_burst_rank_avg;

  localparam int DW = 8;
  localparam int LM = 3;
  localparam int K  = 1 << LM;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [DW-1:0] din;
  logic [1:0]    mode;
  logic [DW-1:0] dout;
  logic          done;

  int n_chk  = 0;
  int n_fail = 0;
  int samp [K];
  int exp_avg;
  int exp_rank [3];

  always #4 clk = ~clk;   // 125 MHz

  burst_rank_avg #(.DATA_W(DW), .LOG2_K(LM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .mode(mode), .dout(dout), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Expected results: the mean by integer division and the top three by sorting.
  task automatic compute_expected();
    int s [K];
    int sum = 0;
    foreach (samp[j]) begin
      s[j] = samp[j];
      sum += samp[j];
    end
    for (int a = 0; a < K; a++)
      for (int b = 0; b < K - 1 - a; b++)
        if (s[b] < s[b+1]) begin
          int t = s[b]; s[b] = s[b+1]; s[b+1] = t;
        end
    exp_avg = sum / K;
    for (int r = 0; r < 3; r++) exp_rank[r] = (r < K) ? s[r] : 0;
  endtask

  task automatic check_results(input string tag);
    mode = 2'b00; #1; check({"R5 R6 mean ", tag}, dout, exp_avg);
    mode = 2'b01; #1; check({"R3 R6 first ", tag}, dout, exp_rank[0]);
    mode = 2'b10; #1; check({"R3 R4 R6 second ", tag}, dout, exp_rank[1]);
    mode = 2'b11; #1; check({"R3 R9 R6 third ", tag}, dout, exp_rank[2]);
  endtask

  task automatic run_burst(input string tag);
    compute_expected();
    @(negedge clk); start = 1'b1; din = DW'(samp[0]);
    for (int j = 1; j < K; j++) begin
      @(negedge clk); start = 1'b0; din = DW'(samp[j]);
    end
    check({"R2 done low before last sample taken ", tag}, int'(done), 0);
    @(negedge clk); start = 1'b0; din = DW'($urandom % 256);
    check({"R2 done high after K samples ", tag}, int'(done), 1);
    check_results(tag);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); din = DW'($urandom % 256);
    end
    check({"R7 done held ", tag}, int'(done), 1);
    check_results({"R7 hold ", tag});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 1'b0; start = 1'b0; din = '0; mode = 2'b00;
    repeat (3) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m); #1;
      check("R1 dout after reset", int'(dout), 0);
    end
    rst_n = 1'b1;

    // Ascending values.
    foreach (samp[j]) samp[j] = j + 1;
    run_burst("ascending");
    // Descending values.
    foreach (samp[j]) samp[j] = 200 - 10 * j;
    run_burst("descending");
    // All samples at the maximum: the sum must not overflow.
    foreach (samp[j]) samp[j] = 255;
    run_burst("all max");
    // Directly after: one non-zero sample, the rest zero; no leftovers.
    foreach (samp[j]) samp[j] = 0;
    samp[K/2] = 17;
    run_burst("R8 R9 single nonzero");
    // Ties with the leading value.
    foreach (samp[j]) samp[j] = (j % 3 == 1) ? 3 : 9;
    run_burst("R4 ties");

    // Restart in the middle of a burst.
    @(negedge clk); start = 1'b1; din = 8'd250;
    @(negedge clk); start = 1'b0; din = 8'd240;
    @(negedge clk); din = 8'd230;
    foreach (samp[j]) samp[j] = j % 4;
    run_burst("R8 mid-burst restart");

    // Random bursts, some from a narrow range to force ties.
    for (int b = 0; b < 24; b++) begin
      foreach (samp[j]) samp[j] = (b % 2 == 1) ? int'($urandom % 6) : int'($urandom % 256);
      run_burst($sformatf("random %0d", b));
    end

    report();
    $finish;
  end

endmodule